// File: doc/BRIEF.md
# Single-Precision to 32-bit Integer Converter

This block turns a packed single-precision floating-point word into a 32-bit integer, either unsigned or two's-complement signed as chosen by an input. The conversion is one combinational path. The path separates the fields and classifies the operand, aligns the significand with a logarithmic right shifter, takes a rounding decision, and clamps the result to the limits of the selected integer type. A single register stage follows the path. That stage presents the integer and three flags one clock after a valid input.

Four rounding modes are available through a 2-bit select. A force input overrides the select with truncation, which serves conversions that must always round toward zero. The three flags are invalid, inexact and input-denormal. Operands that cannot be represented (NaN, infinity, too large, or a negative value for an unsigned target) produce a defined saturated value and raise invalid.

Top module: `f2i_convert`

## Requirements
- R1: After reset `out_valid` and all result outputs are 0. Each cycle with `in_valid` high yields `out_valid` high on the next cycle, carrying that input's result. A cycle without `in_valid` yields `out_valid` low on the next cycle.
- R2: The `rnd_mode` encoding is 00 = nearest with ties to even, 01 = toward +infinity, 10 = toward -infinity, 11 = toward zero. When `force_rtz` is 1, toward-zero applies whatever `rnd_mode` holds.
- R3: For a biased exponent E from 126 to 158, the integer magnitude is the significand (hidden bit included) scaled by 2^(E-127) and truncated. The discarded fraction then rounds the magnitude up by one as follows. In nearest mode it rounds up when the fraction is above one half, or exactly one half with an odd magnitude. In a directed mode that points away from zero for the operand's sign, it rounds up when the fraction is nonzero. Toward zero never rounds up.
- R4: `out_inexact` is 1 when an in-range conversion discards a nonzero fraction and no invalid condition arises. It is also 1 for every nonzero operand below the in-range window (see R10).
- R5: `out_denorm` is 1 exactly when the exponent field is 0 and the fraction field is nonzero.
- R6: A NaN (exponent field all ones, fraction nonzero) of either sign gives 0xFFFFFFFF in unsigned mode and 0 in signed mode, each with invalid.
- R7: A biased exponent of 159 or more that is not a NaN (infinities included) raises invalid. Unsigned mode gives 0xFFFFFFFF for a positive operand and 0 for a negative one. Signed mode gives 0x7FFFFFFF for a positive operand and 0x80000000 for a negative one.
- R8: In unsigned mode, a negative operand whose rounded magnitude is nonzero gives 0 with invalid and without inexact. Every non-NaN negative operand gives 0 in unsigned mode.
- R9: In signed mode, a rounded magnitude above 0x7FFFFFFF (positive operand) or above 0x80000000 (negative operand) is clamped to that limit with invalid and without inexact. A negative operand's magnitude is then negated.
- R10: A nonzero operand with biased exponent below 126 (denormals included) raises inexact and gives 0. The exceptions are toward +infinity on a positive operand, which gives 1, and toward -infinity on a negative operand, which gives 0xFFFFFFFF in signed mode and 0 with invalid in unsigned mode.
- R11: Positive or negative zero gives 0 with no flag raised, in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_bits | input | 32 | Packed single-precision operand |
| to_signed | input | 1 | 1 = signed integer target, 0 = unsigned |
| rnd_mode | input | 2 | Rounding mode select (R2 encoding) |
| force_rtz | input | 1 | Override rounding with toward-zero |
| out_valid | output | 1 | Result present this cycle |
| out_int | output | 32 | Converted integer |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact-result flag |
| out_denorm | output | 1 | Input was denormal |

## Verification
The bench sweeps biased exponents from 120 to 162 with five fraction patterns, both signs, all four modes and both target types. This sweep covers the tiny, in-range and huge boundaries (125/126 and 158/159), and separates a rounding carry from a truncation at every shift distance. The directed vectors cover cases the sweep does not reach on its own: ties at 0.5, 1.5, 2.5 and 3.5, which tell ties-to-even apart from ties-away; exactly 2^31 and -2^31, which separate the positive and negative signed limits; NaNs and infinities of both signs; denormals under the up mode; and the force input against a conflicting mode select. Idle cycles between operands show that the valid output tracks the input cycle for cycle.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  // Rounding mode encoding seen at the rnd_mode port
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  // Operand classes that pick the result path
  typedef enum logic [2:0] {
    CL_ZERO  = 3'd0,
    CL_TINY  = 3'd1,
    CL_RANGE = 3'd2,
    CL_HUGE  = 3'd3,
    CL_NAN   = 3'd4
  } fclass_e;

  // Directed modes that push the magnitude away from zero for this sign
  function automatic logic away_dir(rmode_e m, logic neg);
    return (m == RM_UP && !neg) || (m == RM_DOWN && neg);
  endfunction

  // Whether the truncated magnitude gains one, given the discarded fraction
  // split into its top bit (half) and the OR of the rest
  function automatic logic round_carry(rmode_e m, logic neg, logic lsb,
                                       logic half, logic rest_nz);
    logic c;
    case (m)
      RM_NEAR: c = half && (rest_nz || lsb);
      RM_ZERO: c = 1'b0;
      default: c = away_dir(m, neg) && (half || rest_nz);
    endcase
    return c;
  endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  localparam int W_IN  = EXP_W + FRAC_W + 1,
  localparam int SH_W  = $clog2(INT_W + 1)
) (
  input  logic [W_IN-1:0]   word,
  output logic              sign,
  output fclass_e           cls,
  output logic [FRAC_W:0]   mant,
  output logic [SH_W-1:0]   shamt,
  output logic              denorm
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int HI   = BIAS + INT_W;   // first exponent that cannot fit
  localparam int LO   = BIAS - 1;       // smallest exponent that may round to 1
  localparam logic [EXP_W-1:0] EMAX = '1;

  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic [31:0]       ev;

  assign sign   = word[W_IN-1];
  assign e      = word[W_IN-2:FRAC_W];
  assign f      = word[FRAC_W-1:0];
  assign ev     = 32'(e);
  assign mant   = {(e != '0), f};
  assign denorm = (e == '0) && (f != '0);

  always_comb begin
    shamt = '0;
    if (e == '0 && f == '0) begin
      cls = CL_ZERO;
    end else if (e == EMAX && f != '0) begin
      cls = CL_NAN;
    end else if (ev >= 32'(HI)) begin
      cls = CL_HUGE;
    end else if (ev >= 32'(LO)) begin
      cls   = CL_RANGE;
      shamt = SH_W'(32'(HI - 1) - ev);
    end else begin
      cls = CL_TINY;
    end
  end

endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  localparam int SH_W  = $clog2(INT_W + 1),
  localparam int W     = 2 * INT_W,
  localparam int PAD   = W - FRAC_W - 1
) (
  input  logic [FRAC_W:0]   mant,
  input  logic [SH_W-1:0]   shamt,
  output logic [INT_W-1:0]  ipart,
  output logic              rhalf,
  output logic              rrest
);
  // Upper half is the integer field, lower half the discarded fraction.
  // With no shift the hidden bit weighs 2^(INT_W-1).
  logic [SH_W:0][W-1:0] st;

  assign st[0] = {mant, {PAD{1'b0}}};

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign st[k+1] = shamt[k] ? (st[k] >> (1 << k)) : st[k];
  end

  assign ipart = st[SH_W][W-1:INT_W];
  assign rhalf = st[SH_W][INT_W-1];
  assign rrest = |st[SH_W][INT_W-2:0];

endmodule

// File: rtl/f2i_round_sat.sv
module f2i_round_sat
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  fclass_e           cls,
  input  logic              sign,
  input  logic              to_signed,
  input  rmode_e            mode,
  input  logic [INT_W-1:0]  ipart,
  input  logic              rhalf,
  input  logic              rrest,
  output logic [INT_W-1:0]  res,
  output logic              inv,
  output logic              ixc,
  output logic              ev_carry,
  output logic              ev_clamp,
  output logic              ev_negu
);
  localparam logic [INT_W-1:0] ONES = '1;
  localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] ONE  = INT_W'(1);

  logic             rem_nz;
  logic             carry;
  logic             inc_ovf;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] slim;
  logic [INT_W-1:0] smag;

  assign rem_nz   = rhalf | rrest;
  assign carry    = round_carry(mode, sign, ipart[0], rhalf, rrest);
  assign inc_ovf  = carry && (ipart == ONES);
  assign mag      = (carry && ipart != ONES) ? ipart + ONE : ipart;
  assign slim     = sign ? SMIN : SMAX;
  assign ev_carry = carry && (cls == CL_RANGE);

  always_comb begin
    res      = '0;
    inv      = 1'b0;
    ixc      = 1'b0;
    ev_clamp = 1'b0;
    ev_negu  = 1'b0;
    smag     = '0;
    case (cls)
      CL_ZERO: res = '0;
      CL_NAN: begin
        inv = 1'b1;
        res = to_signed ? '0 : ONES;
      end
      CL_HUGE: begin
        inv = 1'b1;
        if (to_signed) res = sign ? SMIN : SMAX;
        else           res = sign ? '0 : ONES;
      end
      CL_TINY: begin
        ixc = 1'b1;
        if (away_dir(mode, sign)) begin
          if (!sign)          res = ONE;
          else if (to_signed) res = ONES;
          else                inv = 1'b1;
        end
      end
      CL_RANGE: begin
        if (to_signed) begin
          if (mag > slim) begin
            smag     = slim;
            inv      = 1'b1;
            ev_clamp = 1'b1;
          end else begin
            smag = mag;
            ixc  = rem_nz;
          end
          res = sign ? (~smag + ONE) : smag;
        end else if (sign && mag != '0) begin
          inv     = 1'b1;
          ev_negu = 1'b1;
        end else begin
          res = mag;
          inv = inc_ovf;
          ixc = rem_nz;
        end
      end
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  localparam int W_IN  = EXP_W + FRAC_W + 1,
  localparam int SH_W  = $clog2(INT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [W_IN-1:0]   in_bits,
  input  logic              to_signed,
  input  logic [1:0]        rnd_mode,
  input  logic              force_rtz,
  output logic              out_valid,
  output logic [INT_W-1:0]  out_int,
  output logic              out_invalid,
  output logic              out_inexact,
  output logic              out_denorm
);
  rmode_e           mode_eff;
  logic             op_sign;
  fclass_e          op_cls;
  logic [FRAC_W:0]  op_mant;
  logic [SH_W-1:0]  op_shamt;
  logic             op_denorm;
  logic [INT_W-1:0] al_ipart;
  logic             al_half;
  logic             al_rest;
  logic [INT_W-1:0] rs_res;
  logic             rs_inv;
  logic             rs_ixc;
  // Internal events brought out for the checker
  logic             ev_carry;
  logic             ev_clamp;
  logic             ev_negu;

  assign mode_eff = force_rtz ? RM_ZERO : rmode_e'(rnd_mode);

  f2i_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_unpack (
    .word   (in_bits),
    .sign   (op_sign),
    .cls    (op_cls),
    .mant   (op_mant),
    .shamt  (op_shamt),
    .denorm (op_denorm)
  );

  f2i_align #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
    .mant  (op_mant),
    .shamt (op_shamt),
    .ipart (al_ipart),
    .rhalf (al_half),
    .rrest (al_rest)
  );

  f2i_round_sat #(.INT_W(INT_W)) u_round (
    .cls       (op_cls),
    .sign      (op_sign),
    .to_signed (to_signed),
    .mode      (mode_eff),
    .ipart     (al_ipart),
    .rhalf     (al_half),
    .rrest     (al_rest),
    .res       (rs_res),
    .inv       (rs_inv),
    .ixc       (rs_ixc),
    .ev_carry  (ev_carry),
    .ev_clamp  (ev_clamp),
    .ev_negu   (ev_negu)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      out_denorm  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int     <= rs_res;
        out_invalid <= rs_inv;
        out_inexact <= rs_ixc;
        out_denorm  <= op_denorm;
      end
    end
  end

endmodule

// File: rtl/f2i_convert_chk.sv
module f2i_convert_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32,
  localparam int W_IN  = EXP_W + FRAC_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [W_IN-1:0]  in_bits,
  input logic             to_signed,
  input logic             force_rtz,
  input logic             out_valid,
  input logic [INT_W-1:0] out_int,
  input logic             out_invalid,
  input logic             out_inexact,
  input logic             out_denorm,
  input logic             ev_carry,
  input logic             ev_clamp,
  input logic             ev_negu
);
  logic in_nan;
  logic in_den;
  logic in_zero;

  assign in_nan  = (in_bits[W_IN-2:FRAC_W] == '1) && (in_bits[FRAC_W-1:0] != '0);
  assign in_den  = (in_bits[W_IN-2:FRAC_W] == '0) && (in_bits[FRAC_W-1:0] != '0);
  assign in_zero = (in_bits[W_IN-2:0] == '0);

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_rtz_no_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && force_rtz) |-> !ev_carry);

  p_denorm_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_denorm == $past(in_den)));

  p_nan_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_nan) |=> out_invalid);

  p_neg_unsigned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !to_signed && in_bits[W_IN-1] && !in_nan) |=> (out_int == '0));

  p_negu_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_negu) |=> (out_invalid && !out_inexact));

  p_clamp_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_clamp) |=> (out_invalid && !out_inexact));

  p_pos_signed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && to_signed && !in_bits[W_IN-1]) |=> !out_int[INT_W-1]);

  p_zero_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_zero) |=> (out_int == '0 && !out_invalid && !out_inexact));

endmodule

bind f2i_convert f2i_convert_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_bits     (in_bits),
  .to_signed   (to_signed),
  .force_rtz   (force_rtz),
  .out_valid   (out_valid),
  .out_int     (out_int),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact),
  .out_denorm  (out_denorm),
  .ev_carry    (ev_carry),
  .ev_clamp    (ev_clamp),
  .ev_negu     (ev_negu)
);

// File: tb/sim_f2i_convert.sv
module sim_f2i_convert;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_bits = '0;
  logic        to_signed = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        force_rtz = 1'b0;
  logic        out_valid;
  logic [31:0] out_int;
  logic        out_invalid;
  logic        out_inexact;
  logic        out_denorm;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [34:0] exp_q[$];
  logic [31:0] in_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  f2i_convert u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .to_signed(to_signed), .rnd_mode(rnd_mode), .force_rtz(force_rtz),
    .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
    .out_inexact(out_inexact), .out_denorm(out_denorm)
  );

  // Reference: add-an-increment formulation, {invalid, inexact, denorm, value}
  function automatic logic [34:0] model(logic [31:0] x, bit sm, logic [1:0] rmi, bit rtz);
    logic s;
    int unsigned e;
    logic [22:0] f;
    logic [1:0]  rm;
    logic [31:0] sig, d, rem, incr, lim;
    logic [63:0] v;
    logic [32:0] sum;
    bit inv, ixc, idc, nan;
    int sh;
    s = x[31]; e = x[30:23]; f = x[22:0];
    rm = rtz ? 2'b11 : rmi;
    inv = 0; ixc = 0; d = 0; rem = 0; incr = 0;
    sig = (e == 0) ? {2'b00, f, 7'b0} : {2'b01, f, 7'b0};
    idc = (e == 0) && (f != 0);
    nan = (e == 255) && (f != 0);
    if (!sm && nan) s = 1'b0;
    if (sm && nan) begin
      d = 0; inv = 1;
    end else if (e >= 159) begin
      if (sm) d = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
      else    d = s ? 32'h0 : 32'hFFFF_FFFF;
      inv = 1;
    end else if (e >= 126) begin
      sh = 158 - int'(e);
      v = {sig << 1, 32'b0} >> sh;
      d = v[63:32]; rem = v[31:0];
      if (rm == 2'b00)      incr = d[0] ? 32'h8000_0000 : 32'h7FFF_FFFF;
      else if (rm == 2'b11) incr = 0;
      else if ((rm == 2'b01) ^ s) incr = 32'hFFFF_FFFF;
      else incr = 0;
      sum = {1'b0, rem} + {1'b0, incr};
      if (!sm) begin
        if (sum[32]) begin
          if (d != 32'hFFFF_FFFF) d = d + 1; else inv = 1;
        end
        if (d != 0 && s) begin d = 0; inv = 1; end
        else if (rem != 0) ixc = 1;
      end else begin
        if (sum[32] && d != 32'hFFFF_FFFF) d = d + 1;
        lim = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
        if (d > lim) begin d = lim; inv = 1; end
        else if (rem != 0) ixc = 1;
        if (s) d = 32'h0 - d;
      end
    end else begin
      d = 0;
      if (e != 0 || f != 0) begin
        ixc = 1;
        if (rm == 2'b01 && !s) d = 1;
        else if (rm == 2'b10 && s) begin
          if (sm) d = 32'hFFFF_FFFF; else inv = 1;
        end
      end
    end
    return {inv, ixc, idc, d};
  endfunction

  task automatic send(input logic [31:0] x, input bit sm, input logic [1:0] rm,
                      input bit rtz, input string tag);
    @(negedge clk);
    in_bits = x; to_signed = sm; rnd_mode = rm; force_rtz = rtz; in_valid = 1'b1;
    exp_q.push_back(model(x, sm, rm, rtz));
    in_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic logic [22:0] fpat(int i);
    case (i)
      0: return 23'h000000;
      1: return 23'h000001;
      2: return 23'h400000;
      3: return 23'h7FFFFF;
      default: return 23'h2AAAAA;
    endcase
  endfunction

  // Monitor: pops the scoreboard each time a result appears
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R1: unexpected out_valid, got res=%h expected no result", out_int);
        end else begin
          logic [34:0] ex;
          logic [31:0] xi;
          string tg;
          ex = exp_q.pop_front(); xi = in_q.pop_front(); tg = tag_q.pop_front();
          if ({out_invalid, out_inexact, out_denorm, out_int} !== ex) begin
            fails++;
            $display("FAIL %s: in=%h got res=%h inv=%b ixc=%b den=%b expected res=%h inv=%b ixc=%b den=%b",
                     tg, xi, out_int, out_invalid, out_inexact, out_denorm,
                     ex[31:0], ex[34], ex[33], ex[32]);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_int !== 32'h0 || out_invalid !== 1'b0 ||
        out_inexact !== 1'b0 || out_denorm !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset state got valid=%b res=%h expected valid=0 res=0", out_valid, out_int);
    end
    rst_n = 1'b1;
    idle(2);

    // R3 rounding of exact and halfway values
    send(32'h3F800000, 0, 2'b00, 0, "R3 one");
    send(32'h3FC00000, 0, 2'b00, 0, "R3 1.5 nearest");
    send(32'h40200000, 0, 2'b00, 0, "R3 2.5 tie to even");
    send(32'h40600000, 1, 2'b00, 0, "R3 3.5 tie to even");
    send(32'h3F000000, 0, 2'b00, 0, "R3 0.5 tie to zero");
    send(32'h3F400000, 1, 2'b00, 0, "R3 0.75 nearest");
    // R2 mode encoding and override
    send(32'h3FC00000, 0, 2'b01, 0, "R2 1.5 up");
    send(32'h3FC00000, 0, 2'b10, 0, "R2 1.5 down");
    send(32'h3FC00000, 0, 2'b11, 0, "R2 1.5 zero");
    send(32'h3FC00000, 0, 2'b01, 1, "R2 force overrides up");
    send(32'hBFC00000, 1, 2'b10, 1, "R2 force overrides down");
    send(32'hBFC00000, 1, 2'b01, 0, "R2 -1.5 up");
    send(32'hBFC00000, 1, 2'b10, 0, "R2 -1.5 down");
    // R4 inexact
    send(32'h3FA00000, 1, 2'b11, 0, "R4 1.25 inexact");
    idle(2);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: idle got out_valid=%b expected 0", out_valid);
    end
    // R5 denormals
    send(32'h00000001, 0, 2'b00, 0, "R5 denormal nearest");
    send(32'h00000001, 1, 2'b01, 0, "R5 denormal up");
    send(32'h807FFFFF, 1, 2'b10, 0, "R5 negative denormal down");
    // R6 NaN
    send(32'h7FC00000, 0, 2'b00, 0, "R6 qnan unsigned");
    send(32'h7FC00000, 1, 2'b00, 0, "R6 qnan signed");
    send(32'hFFC00001, 0, 2'b01, 0, "R6 negative nan unsigned");
    send(32'h7F800001, 1, 2'b10, 0, "R6 snan signed");
    // R7 huge and infinity
    send(32'h7F800000, 0, 2'b00, 0, "R7 +inf unsigned");
    send(32'h7F800000, 1, 2'b00, 0, "R7 +inf signed");
    send(32'hFF800000, 1, 2'b00, 0, "R7 -inf signed");
    send(32'hFF800000, 0, 2'b00, 0, "R7 -inf unsigned");
    send(32'h4F800000, 0, 2'b00, 0, "R7 2^32 unsigned");
    send(32'h4F7FFFFF, 0, 2'b01, 0, "R7 largest in range unsigned");
    // R8 negative to unsigned
    send(32'hBF400000, 0, 2'b00, 0, "R8 -0.75 unsigned");
    send(32'hBFC00000, 0, 2'b11, 0, "R8 -1.5 unsigned");
    send(32'hBE800000, 0, 2'b00, 0, "R8 -0.25 unsigned nearest");
    // R9 signed limits
    send(32'h4F000000, 1, 2'b00, 0, "R9 2^31 signed clamp");
    send(32'hCF000000, 1, 2'b00, 0, "R9 -2^31 signed exact");
    send(32'h4EFFFFFF, 1, 2'b01, 0, "R9 below 2^31 signed");
    send(32'h4F000000, 0, 2'b00, 0, "R9 2^31 unsigned fits");
    // R10 tiny operands
    send(32'h3E800000, 0, 2'b01, 0, "R10 0.25 up");
    send(32'hBE800000, 1, 2'b10, 0, "R10 -0.25 down signed");
    send(32'hBE800000, 0, 2'b10, 0, "R10 -0.25 down unsigned");
    send(32'h3E800000, 1, 2'b10, 0, "R10 0.25 down");
    // R11 zeros
    send(32'h00000000, 0, 2'b01, 0, "R11 +0 unsigned");
    send(32'h80000000, 1, 2'b10, 0, "R11 -0 signed");
    send(32'h80000000, 0, 2'b10, 0, "R11 -0 unsigned");

    // R3 sweep over the window edges, every mode, sign and target
    for (int e = 120; e <= 162; e++)
      for (int fi = 0; fi < 5; fi++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 4; m++)
            for (int t = 0; t < 2; t++)
              send({s[0], e[7:0], fpat(fi)}, t[0], m[1:0], 1'b0, "R3 sweep");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1: results missing, got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule